// File: doc/BRIEF.md
# Skew-Driven Thermometer Tuning Controller

This block steers one tunable clock buffer inside a deskew loop. Each clock cycle it may receive a signed skew sample that has already been digitised. The sample is the leaf clock arrival time minus the reference clock arrival time, counted in picoseconds. The block compares the sample against a dead band that is symmetric about zero. If the leaf arrives late, it asks for less delay. If the leaf arrives early, it asks for more delay. If the sample lies inside the band, it makes no request.

Each request is a pulse two cycles wide, and each pulse moves the buffer's thermometer control word by exactly one bit. While a pulse is in flight, the block takes no new sample, which gives the loop time to settle. A lock flag reports when the skew has stayed inside the band for a set number of comparisons in a row.

The step size is the tuning range divided by one less than the word width. The dead band is one and a half steps, rounded down to whole picoseconds. Both values are computed from parameters.

Top module: `skew_tune_ctrl`

## Requirements
- R1: When a comparison sees skew greater than +TH, it raises `dn_o`. TH is floor(3*RANGE_PS / (2*(NBITS-1))), which is 37 with the defaults.
- R2: When a comparison sees skew less than -TH, it raises `up_o`.
- R3: A skew inside [-TH, +TH], with both ends included, raises no request and leaves `tune_word_o` unchanged.
- R4: `up_o` and `dn_o` are never high in the same cycle.
- R5: A request stays high for exactly two cycles. `tune_word_o` changes exactly once, by one bit, on the edge where the request falls.
- R6: `tune_word_o` is always a thermometer code made of ones filled up from bit 0. UP sets the lowest clear bit. DOWN clears the highest set bit.
- R7: The word saturates. UP with all bits set, and DOWN with no bits set, each complete a normal two-cycle pulse but leave the word unchanged.
- R8: During reset the word holds floor(NBITS/2) ones from bit 0 (3'b001 with the defaults), no request is raised, and `locked_o` is low.
- R9: The skew input is ignored while a request is high. The next comparison happens on the first edge after the request falls.
- R10: `locked_o` rises on the edge of the LOCK_N-th consecutive in-band comparison, with LOCK_N defaulting to 4. It clears on the edge of any out-of-band comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| skew_i | input | SKEW_W | Signed skew in ps, leaf minus reference |
| up_o | output | 1 | Request to add one delay step |
| dn_o | output | 1 | Request to remove one delay step |
| tune_word_o | output | NBITS | Thermometer control word for the buffer |
| locked_o | output | 1 | Skew has stayed in band for LOCK_N comparisons |

## Verification
A corrupted phase state shows up at the ports almost at once. The pulse length changes, the word moves on the wrong edge, or the block reacts to a sample taken during a pulse. The next request makes any of these visible within three cycles. A wrong word register breaks the thermometer pattern, or the one-bit step, on the first edge where it updates. A miscounted lock streak shows up as `locked_o` rising one comparison early or late, or failing to clear when the first out-of-band sample arrives.

// File: rtl/skew_tune_ctrl.sv
module skew_tune_ctrl #(
  parameter int RANGE_PS = 50,
  parameter int NBITS    = 3,
  parameter int SKEW_W   = 10,
  parameter int LOCK_N   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [SKEW_W-1:0] skew_i,
  output logic                     up_o,
  output logic                     dn_o,
  output logic [NBITS-1:0]         tune_word_o,
  output logic                     locked_o
);

  localparam int STEP_PS = RANGE_PS / (NBITS - 1);
  localparam int TH_PS   = (3 * RANGE_PS) / (2 * (NBITS - 1));
  localparam int LCW     = $clog2(LOCK_N + 1);
  localparam logic signed [SKEW_W-1:0] TH_HI = SKEW_W'(TH_PS);
  localparam logic signed [SKEW_W-1:0] TH_LO = -TH_HI;
  localparam logic [NBITS-1:0] MID = NBITS'((1 << (NBITS / 2)) - 1);

  logic [1:0]     ph_q;
  logic [LCW-1:0] cnt_q;
  logic           late, early;

  assign late     = skew_i > TH_HI;
  assign early    = skew_i < TH_LO;
  assign locked_o = (cnt_q == LCW'(LOCK_N));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q        <= 2'd0;
      up_o        <= 1'b0;
      dn_o        <= 1'b0;
      tune_word_o <= MID;
      cnt_q       <= '0;
    end else begin
      case (ph_q)
        2'd0: begin
          if (late) begin
            dn_o  <= 1'b1;
            ph_q  <= 2'd1;
            cnt_q <= '0;
          end else if (early) begin
            up_o  <= 1'b1;
            ph_q  <= 2'd1;
            cnt_q <= '0;
          end else if (!locked_o) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        2'd1: ph_q <= 2'd2;
        default: begin
          ph_q <= 2'd0;
          up_o <= 1'b0;
          dn_o <= 1'b0;
          if (up_o)      tune_word_o <= {tune_word_o[NBITS-2:0], 1'b1};
          else if (dn_o) tune_word_o <= {1'b0, tune_word_o[NBITS-1:1]};
        end
      endcase
    end
  end

  AST_UP_DN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o)); // R4

  AST_REQ_TWO_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o || dn_o) |=> (up_o || dn_o) ##1 !(up_o || dn_o)); // R5

  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tune_word_o) |->
      ($countones(tune_word_o) + 1 == $countones($past(tune_word_o))) ||
      ($countones(tune_word_o) == $countones($past(tune_word_o)) + 1)); // R5

  AST_WORD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tune_word_o) |-> $past(up_o || dn_o) && !(up_o || dn_o)); // R5

  AST_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tune_word_o + 1'b1) & tune_word_o) == 0); // R6

  AST_HOLD_IN_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_o && !dn_o && !late && !early) |=> (!up_o && !dn_o && $stable(tune_word_o))); // R3

  AST_STEP_POS: assert final (STEP_PS > 0); // R1

endmodule

// File: tb/skew_tune_ctrl_tb_top.sv
module skew_tune_ctrl_tb_top;
  localparam int RANGE = 50;
  localparam int NB    = 3;
  localparam int SW    = 10;
  localparam int LN    = 4;
  localparam int TH    = (3 * RANGE) / (2 * (NB - 1));

  typedef struct {
    logic          up;
    logic          dn;
    logic [NB-1:0] word;
    logic          lock;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [SW-1:0] skew = '0;
  logic up, dn, locked;
  logic [NB-1:0] word;

  exp_t q[$];
  int checks = 0, errors = 0;
  int lvl = NB / 2;
  int streak = 0;

  always #4 clk = ~clk;

  skew_tune_ctrl #(.RANGE_PS(RANGE), .NBITS(NB), .SKEW_W(SW), .LOCK_N(LN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .skew_i(skew),
    .up_o(up), .dn_o(dn), .tune_word_o(word), .locked_o(locked));

  function automatic logic [NB-1:0] therm(int n);
    return NB'((1 << n) - 1);
  endfunction

  task automatic chk(string tag, logic [NB+2:0] act, logic [NB+2:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act{up,dn,lock,word}=%b exp=%b", tag, act, expv);
    end
  endtask

  task automatic lock_step(int s, string tag);
    exp_t e;
    skew = SW'(s);
    streak++;
    e.up = 1'b0; e.dn = 1'b0; e.word = therm(lvl); e.lock = (streak >= LN); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic req_step(int s, bit is_up, string tag);
    exp_t e;
    logic [NB-1:0] old_w;
    skew = SW'(s);
    streak = 0;
    old_w = therm(lvl);
    if (is_up && lvl < NB) lvl++;
    else if (!is_up && lvl > 0) lvl--;
    e.up = is_up; e.dn = !is_up; e.word = old_w; e.lock = 1'b0; e.tag = tag;
    q.push_back(e);
    q.push_back(e);
    e.up = 1'b0; e.dn = 1'b0; e.word = therm(lvl);
    q.push_back(e);
    @(negedge clk);
    skew = SW'(-s); // R9: opposite extreme during the pulse must be ignored
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, {up, dn, locked, word}, {e.up, e.dn, e.lock, e.word});
      end
    end
  end

  initial begin : watchdog
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("R8 reset state", {up, dn, locked, word}, {1'b0, 1'b0, 1'b0, therm(NB / 2)});
    rst_n = 1'b1;
    lock_step(0,   "R10 in-band 1");
    lock_step(5,   "R10 in-band 2");
    lock_step(-5,  "R10 in-band 3");
    lock_step(0,   "R10 locked at 4th");
    lock_step(TH,  "R3 +TH edge in band");
    lock_step(-TH, "R3 -TH edge in band");
    req_step(TH + 1, 1'b0, "R1 late skew DOWN, R10 clear");
    req_step(200, 1'b0, "R7 DOWN saturated at zero");
    req_step(-(TH + 1), 1'b1, "R2 early skew UP");
    req_step(-100, 1'b1, "R6 UP sets next bit");
    req_step(-60, 1'b1, "R6 UP to full");
    req_step(-300, 1'b1, "R7 UP saturated at full");
    lock_step(10,  "R3 word held in band");
    req_step(90, 1'b0, "R5 single step down");
    lock_step(-TH, "R9 compare right after pulse");
    lock_step(0,   "R10 streak 2");
    lock_step(1,   "R10 streak 3");
    lock_step(-1,  "R10 streak 4 locks");
    lock_step(0,   "R10 stays locked");
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard queue not drained act=%0d exp=0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule